// File: doc/BRIEF.md
# Duplex Parity Memory with Automatic Failover

This block stores every word twice, once in each of two internal RAM banks, and keeps an even-parity bit with each stored copy. A requester writes and reads through a single valid/ready request port. Every accepted request goes to both banks in the same cycle. One bank is marked prime. On a read, the prime copy is returned unless its parity check fails. In that case the other copy is returned, the prime marking moves to the other bank, and the controller copies the good word over the bad one without any help from software.

When only the non-prime copy fails, the prime data is returned and the non-prime copy is repaired, with no change of roles. When both copies fail, the read is flagged as uncorrectable and nothing is rewritten. Every repair is a single hardware write cycle. During that cycle `req_ready` is low. A request held on the port then stays pending and is taken on the next cycle.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold the request stable. The read response cannot be stalled: `rsp_valid` is high for exactly one cycle, the cycle after the read is accepted. Two status pins, `prime_sel` and `err_count`, are plain outputs. The `req_inject` pins are a test aid. A set bit flips the stored parity of that bank's copy on a write, which emulates an upset.

Top module: `dpm_top`

## Requirements
- R1: After reset `prime_sel` is 0 (bank 0 is prime), `err_count` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write stores the same data in both banks. A read of an address with no parity error returns the last data written there, with `rsp_valid` high only in the cycle after the read is accepted and `rsp_uncorr` low.
- R3: Each bank stores the even-parity bit of the data (XOR of the data bits). A write with `req_inject[b]` set stores the inverted parity in bank b only (bit 0 is bank 0, bit 1 is bank 1). A later clean write to that address stores correct parity again.
- R4: If the prime copy fails parity and the other copy passes, the other copy's data is returned and `prime_sel` toggles after the response cycle.
- R5: If only the non-prime copy fails parity, the prime data is returned and `prime_sel` does not change.
- R6: On a read where exactly one copy fails, the failed copy is rewritten with the good word during the response cycle, with `req_ready` low in that cycle. A later read of that address finds no error.
- R7: If both copies fail parity, `rsp_uncorr` is high with `rsp_valid` and the prime data is returned. There is no role swap, no count change and no write-back: `req_ready` stays high, and a re-read is uncorrectable again.
- R8: `err_count` increments by one after each read on which exactly one copy failed, and it holds at 255 once it reaches 255.
- R9: A request presented while `req_ready` is low is not taken in that cycle. If it is held, it is taken on the next cycle and takes effect exactly once.
- R10: A read accepted in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 16 | Write data |
| req_inject | input | 2 | Per-bank parity inversion on write (test aid) |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | 16 | Read data |
| rsp_uncorr | output | 1 | Both copies failed parity (with rsp_valid) |
| prime_sel | output | 1 | Index of the bank currently prime |
| err_count | output | 8 | Saturating count of corrected errors |

## Verification
A wrong prime marking would show on the `prime_sel` pin one cycle after the response. It would also show on the data pins: returned data would be wrong, or a clean re-read would still raise the count on the next access. A missing or misdirected repair would not show at once. It shows on the second read of the same address, which raises `err_count` again or flags uncorrectable. A wrong stall shows in the response cycle as `req_ready` at the wrong level, or as a held request taken twice or not at all.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_ADDR_W = 10;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned NUM_BANKS  = 2;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_t;
endpackage

// File: rtl/dpm_bank.sv
module dpm_bank #(
  parameter int unsigned WORD_W = 17,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[addr] <= wword;
      else    rword <= cells[addr];
    end
  end
endmodule

// File: rtl/dpm_resolve.sv
module dpm_resolve #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W:0]   word0,
  input  logic [DATA_W:0]   word1,
  input  logic              prime,
  output logic [DATA_W-1:0] data,
  output logic              prime_bad,
  output logic              sec_bad,
  output logic              use_sec,
  output logic              both_bad,
  output logic [DATA_W:0]   good_word
);
  logic [DATA_W:0] w_prime;
  logic [DATA_W:0] w_sec;

  always_comb begin
    w_prime   = prime ? word1 : word0;
    w_sec     = prime ? word0 : word1;
    // stored word is {parity, data}; even parity => XOR over all bits is 0
    prime_bad = ^w_prime;
    sec_bad   = ^w_sec;
    both_bad  = prime_bad && sec_bad;
    use_sec   = prime_bad && !sec_bad;
    good_word = use_sec ? w_sec : w_prime;
    data      = good_word[DATA_W-1:0];
  end
endmodule

// File: rtl/dpm_satcnt.sv
module dpm_satcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != TOP) |=> (count == $past(count) + 1'b1)); // R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R8
endmodule

// File: rtl/dpm_top.sv
module dpm_top #(
  parameter int unsigned DATA_W = dpm_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W = dpm_pkg::DEF_ADDR_W,
  parameter int unsigned CNT_W  = dpm_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_inject,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_uncorr,
  output logic              prime_sel,
  output logic [CNT_W-1:0]  err_count
);
  import dpm_pkg::*;

  localparam int unsigned WORD_W = DATA_W + 1;

  logic                           fire;
  logic                           rd_pend;
  logic [ADDR_W-1:0]              rd_addr;
  logic                           prime_q;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q;
  logic                           p_bad, s_bad, use_sec, both_bad;
  logic [WORD_W-1:0]              good_word;
  logic                           repair;
  bank_t                          fix_bank;
  logic                           wr_par;

  assign fire     = req_valid && req_ready;
  assign wr_par   = ^req_wdata;
  assign repair   = rd_pend && (p_bad ^ s_bad);
  assign fix_bank = bank_t'(p_bad ? prime_q : !prime_q);
  assign req_ready = !repair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_addr <= '0;
      prime_q <= BANK_A;
    end else begin
      rd_pend <= fire && !req_write;
      if (fire) rd_addr <= req_addr;
      if (repair && p_bad) prime_q <= !prime_q;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              b_fix;
    logic              b_en;
    logic              b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [WORD_W-1:0] b_word;

    always_comb begin
      b_fix = repair && (fix_bank == bank_t'(b));
      if (b_fix) begin
        b_en   = 1'b1;
        b_we   = 1'b1;
        b_addr = rd_addr;
        b_word = good_word;
      end else begin
        b_en   = fire;
        b_we   = fire && req_write;
        b_addr = req_addr;
        b_word = {wr_par ^ req_inject[b], req_wdata};
      end
    end

    dpm_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) bank_i (
      .clk   (clk),
      .en    (b_en),
      .we    (b_we),
      .addr  (b_addr),
      .wword (b_word),
      .rword (bank_q[b])
    );
  end

  dpm_resolve #(.DATA_W(DATA_W)) resolve_i (
    .word0     (bank_q[0]),
    .word1     (bank_q[1]),
    .prime     (prime_q),
    .data      (rsp_data),
    .prime_bad (p_bad),
    .sec_bad   (s_bad),
    .use_sec   (use_sec),
    .both_bad  (both_bad),
    .good_word (good_word)
  );

  dpm_satcnt #(.CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (repair),
    .count (err_count)
  );

  assign rsp_valid  = rd_pend;
  assign rsp_uncorr = rd_pend && both_bad;
  assign prime_sel  = prime_q;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R2
  AST_SWAP_ON_PRIME_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && use_sec) |=> (prime_sel != $past(prime_sel))); // R4
  AST_NO_SWAP_SEC_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !p_bad) |=> $stable(prime_sel)); // R5
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R6
  AST_UNCORR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncorr |=> ($stable(prime_sel) && $stable(err_count))); // R7
  AST_UNCORR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncorr |-> req_ready); // R7
endmodule

// File: tb/dpm_top_tb_top.sv
`timescale 1ns/1ps
module dpm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_inject = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rsp_uncorr;
  logic        prime_sel;
  logic [7:0]  err_count;

  int n_run = 0;
  int n_fail = 0;
  logic exp_prime = 1'b0;
  int   exp_cnt = 0;

  always #2 clk = ~clk;

  dpm_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_inject(req_inject),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_uncorr(rsp_uncorr),
    .prime_sel(prime_sel), .err_count(err_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // presents a request at a negedge, waits for acceptance; returns at the
  // negedge of the following cycle with the request withdrawn
  task automatic issue(input logic wr, input logic [9:0] a, input logic [15:0] d,
                       input logic [1:0] inj);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_inject = inj;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_inject = 2'b00;
  endtask

  function automatic logic [1:0] sec_mask();
    return exp_prime ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] prime_mask();
    return exp_prime ? 2'b10 : 2'b01;
  endfunction

  task automatic bump_cnt();
    if (exp_cnt < 255) exp_cnt++;
  endtask

  task automatic t_reset();
    check(prime_sel == 1'b0, "R1 prime_sel", prime_sel, 0);
    check(err_count == 8'd0, "R1 err_count", err_count, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_basic();
    issue(1'b1, 10'h001, 16'hA5C3, 2'b00);
    issue(1'b1, 10'h3FF, 16'h0001, 2'b00);
    issue(1'b1, 10'h000, 16'hFFFF, 2'b00);
    issue(1'b0, 10'h001, 16'h0, 2'b00);
    check(rsp_valid == 1'b1, "R2 rsp_valid", rsp_valid, 1);
    check(rsp_data == 16'hA5C3, "R2 data 001", rsp_data, 16'hA5C3);
    check(rsp_uncorr == 1'b0, "R2 uncorr", rsp_uncorr, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 rsp_valid one cycle", rsp_valid, 0);
    issue(1'b0, 10'h3FF, 16'h0, 2'b00);
    check(rsp_data == 16'h0001, "R2 data 3FF", rsp_data, 16'h0001);
    issue(1'b0, 10'h000, 16'h0, 2'b00);
    check(rsp_data == 16'hFFFF, "R2 data 000", rsp_data, 16'hFFFF);
    check(err_count == 8'd0, "R2 no errors", err_count, 0);
  endtask

  task automatic t_raw();
    issue(1'b1, 10'h055, 16'h1234, 2'b00);
    issue(1'b0, 10'h055, 16'h0, 2'b00);
    check(rsp_data == 16'h1234, "R10 read after write", rsp_data, 16'h1234);
    issue(1'b1, 10'h055, 16'h4321, 2'b00);
    issue(1'b0, 10'h055, 16'h0, 2'b00);
    check(rsp_data == 16'h4321, "R10 read after overwrite", rsp_data, 16'h4321);
  endtask

  task automatic t_sec_err();
    issue(1'b1, 10'h100, 16'h00F0, sec_mask());
    issue(1'b0, 10'h100, 16'h0, 2'b00);
    check(rsp_data == 16'h00F0, "R5 prime data", rsp_data, 16'h00F0);
    check(req_ready == 1'b0, "R6 stall on repair", req_ready, 0);
    check(rsp_uncorr == 1'b0, "R5 not uncorr", rsp_uncorr, 0);
    bump_cnt();
    @(negedge clk);
    check(prime_sel == exp_prime, "R5 no swap", prime_sel, exp_prime);
    check(err_count == exp_cnt, "R8 count sec", err_count, exp_cnt);
    issue(1'b0, 10'h100, 16'h0, 2'b00);
    check(req_ready == 1'b1, "R6 repaired no stall", req_ready, 1);
    @(negedge clk);
    check(err_count == exp_cnt, "R6 sec repaired", err_count, exp_cnt);
  endtask

  task automatic t_prime_err();
    issue(1'b1, 10'h200, 16'hBEEF, prime_mask());
    issue(1'b0, 10'h200, 16'h0, 2'b00);
    check(rsp_data == 16'hBEEF, "R4 secondary data", rsp_data, 16'hBEEF);
    check(req_ready == 1'b0, "R6 stall prime repair", req_ready, 0);
    exp_prime = !exp_prime;
    bump_cnt();
    @(negedge clk);
    check(prime_sel == exp_prime, "R4 swap", prime_sel, exp_prime);
    check(err_count == exp_cnt, "R3 R8 count prime", err_count, exp_cnt);
    issue(1'b0, 10'h200, 16'h0, 2'b00);
    check(rsp_data == 16'hBEEF, "R6 data after repair", rsp_data, 16'hBEEF);
    @(negedge clk);
    check(err_count == exp_cnt, "R6 prime repaired", err_count, exp_cnt);
    check(prime_sel == exp_prime, "R6 no second swap", prime_sel, exp_prime);
  endtask

  task automatic t_both();
    issue(1'b1, 10'h0AA, 16'h5A5A, 2'b11);
    issue(1'b0, 10'h0AA, 16'h0, 2'b00);
    check(rsp_uncorr == 1'b1, "R7 uncorr", rsp_uncorr, 1);
    check(rsp_data == 16'h5A5A, "R7 prime data", rsp_data, 16'h5A5A);
    check(req_ready == 1'b1, "R7 no write-back", req_ready, 1);
    @(negedge clk);
    check(prime_sel == exp_prime, "R7 no swap", prime_sel, exp_prime);
    check(err_count == exp_cnt, "R7 no count", err_count, exp_cnt);
    issue(1'b0, 10'h0AA, 16'h0, 2'b00);
    check(rsp_uncorr == 1'b1, "R7 still uncorr", rsp_uncorr, 1);
    issue(1'b1, 10'h0AA, 16'h6B6B, 2'b00);
    issue(1'b0, 10'h0AA, 16'h0, 2'b00);
    check(rsp_uncorr == 1'b0, "R3 clean rewrite", rsp_uncorr, 0);
    check(rsp_data == 16'h6B6B, "R3 clean data", rsp_data, 16'h6B6B);
  endtask

  task automatic t_stall();
    issue(1'b1, 10'h123, 16'h1111, sec_mask());
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h123;
    @(posedge clk);
    @(negedge clk);
    bump_cnt();
    check(req_ready == 1'b0, "R9 ready low", req_ready, 0);
    req_write = 1'b1; req_wdata = 16'h2222;
    @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready back", req_ready, 1);
    check(rsp_valid == 1'b0, "R9 no extra response", rsp_valid, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 10'h123, 16'h0, 2'b00);
    check(rsp_data == 16'h2222, "R9 held write taken", rsp_data, 16'h2222);
    check(req_ready == 1'b1, "R9 no error on new data", req_ready, 1);
    @(negedge clk);
    check(err_count == exp_cnt, "R9 count", err_count, exp_cnt);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 260; i++) begin
      issue(1'b1, 10'h300, 16'(i), sec_mask());
      issue(1'b0, 10'h300, 16'h0, 2'b00);
      bump_cnt();
      @(negedge clk);
    end
    check(err_count == 8'd255, "R8 saturate", err_count, 255);
    check(prime_sel == exp_prime, "R5 no swap in loop", prime_sel, exp_prime);
  endtask

  initial begin
    #(4 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_raw();
    t_sec_err();
    t_prime_err();
    t_both();
    t_stall();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule